// File: doc/BRIEF.md
# Tiny Bytecode Processor Core

This core executes a fixed program of 256 one-byte instructions held in an external read-only program memory. The memory has a synchronous read port: the core presents an address and receives that byte on the next clock. After one priming fetch following reset, the core retires one instruction per clock. Each instruction byte splits into an operation code and an argument nibble. Control flow uses only sixteen fixed entry points, one at every multiple of 16. There is a call/return path through a 256-slot return stack and a counted loop branch. A dedicated execute unit holds a 32-bit accumulator and eight general registers.

Characters leave the core on a valid/ready byte stream. When the emit instruction executes, the byte and `out_valid` are registered and presented on the next cycle. `out_valid` never waits for `out_ready`. Once raised, `out_valid` and `out_data` stay unchanged until `out_ready` is sampled high, and the transfer completes on that edge. While a byte is waiting, the core freezes its program counter and executes nothing. When `out_ready` is held high, each emit yields a single-cycle valid pulse.

Top module: `bytecore`

## Requirements
- R1: While `rst` is high and after its release, the PC, the stack pointer, every return stack slot, the accumulator and all eight general registers are zero. `pm_addr` reads 0 and `out_valid` is low during reset.
- R2: An instruction byte has the operation in bits 3:0. The argument nibble N is bits 7:4, the direction flag D is bit 7, and the register index R is bits 6:4. An instruction that does not redirect flow moves the PC to PC+1, and address 255 is followed by address 0.
- R3: Operation 1 (call) writes PC+1 into the stack slot addressed by SP, then increments SP and jumps to N×16.
- R4: Operation 0 (return) decrements SP, then jumps to the address held in the slot SP now addresses. SP wraps both ways, so a return with no matching call lands on address 0.
- R5: Operation 2 (loop) decrements the accumulator. If the new value is nonzero it jumps to N×16; otherwise it continues at PC+1.
- R6: Operation 3 (emit) drives the low byte of the accumulator on `out_data` with `out_valid` high. The pair holds stable until accepted, and the core stalls for as long as it waits.
- R7: Operation 4 loads the accumulator with N−8. Operation 5 adds N−8 to it, and operation 6 adds 1, with N−8 read as a signed value from −8 to 7.
- R8: Operation 7 copies the accumulator into register R when D is 1, and copies register R into the accumulator when D is 0.
- R9: Operations 8, 9, 10, 13, 14 and 15 compute, with G the register R and A the accumulator: G+A, G−A, G×A (low 32 bits), unsigned G≤A as 1 or 0, G|A, and ~(G&A). The result goes to register R when D is 1 and to the accumulator when D is 0.
- R10: Operations 11 and 12 change no register and advance the PC by one.
- R11: Absent back-pressure, one instruction retires per clock. `pm_addr` carries the address of the next instruction, and it advances each cycle through straight-line code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 8 | Program memory read address |
| pm_data | input | 8 | Program memory byte, one cycle after its address |
| out_data | output | 8 | Emitted character |
| out_valid | output | 1 | Character present on `out_data` |
| out_ready | input | 1 | Consumer accepts the character |

## Verification
The assertions assume that `pm_data` always returns the byte of the address presented one clock earlier, and the bench builds its program memory as a registered array that does exactly that. They also assume that `out_ready` is a clean level that changes only between edges, so the bench drives it from a pseudo-random pattern a little after each rising edge. Every program the bench loads runs into a known self-call loop or repeats a known output cycle, so the expected character stream is fully determined by the requirements.

// File: rtl/bytecore_pkg.sv
package bytecore_pkg;

  localparam int INSTR_W = 8;
  localparam int NREG    = 8;
  localparam int RIDX_W  = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_RET   = 4'd0,
    OP_JSR   = 4'd1,
    OP_LOOP  = 4'd2,
    OP_EMIT  = 4'd3,
    OP_SETK  = 4'd4,
    OP_ADDK  = 4'd5,
    OP_INC1  = 4'd6,
    OP_XFER  = 4'd7,
    OP_ADD   = 4'd8,
    OP_SUB   = 4'd9,
    OP_MUL   = 4'd10,
    OP_IDLE0 = 4'd11,
    OP_IDLE1 = 4'd12,
    OP_LEU   = 4'd13,
    OP_OR    = 4'd14,
    OP_NAND  = 4'd15
  } op_e;

  typedef struct packed {
    logic [3:0] arg;
    op_e        op;
  } instr_t;

endpackage

// File: rtl/bytecore_rstack.sv
module bytecore_rstack
  import bytecore_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_addr,
  output logic [PC_W-1:0] ret_addr
);

  localparam int DEPTH = 1 << PC_W;

  logic [PC_W-1:0] slot_q [DEPTH];
  logic [PC_W-1:0] sp_q;
  logic [PC_W-1:0] sp_dec;

  assign sp_dec   = sp_q - 1'b1;
  assign ret_addr = slot_q[sp_dec];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push) begin
      slot_q[sp_q] <= push_addr;
      sp_q         <= sp_q + 1'b1;
    end else if (pop) begin
      sp_q <= sp_dec;
    end
  end

  AST_PUSH_UP: assert property (@(posedge clk) disable iff (rst)
    push |=> (sp_q == $past(sp_q) + 1'b1) && (slot_q[$past(sp_q)] == $past(push_addr))); // R3

  AST_POP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> sp_q == $past(sp_q) - 1'b1); // R4

endmodule

// File: rtl/bytecore_exec.sv
module bytecore_exec
  import bytecore_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  op_e               op,
  input  logic              dsel,
  input  logic [RIDX_W-1:0] rsel,
  input  logic [3:0]        narg,
  output logic [DATA_W-1:0] acc
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] gr_q [NREG];
  logic [DATA_W-1:0] gsel;
  logic [DATA_W-1:0] konst;
  logic [DATA_W-1:0] res;
  logic              alu_op;

  // N-8 in four-bit two's complement is {~N[3], N[2:0]}
  assign konst = {{(DATA_W-3){~narg[3]}}, narg[2:0]};
  assign gsel  = gr_q[rsel];
  assign acc   = acc_q;

  always_comb begin
    alu_op = 1'b1;
    res    = '0;
    unique case (op)
      OP_ADD:  res = gsel + acc_q;
      OP_SUB:  res = gsel - acc_q;
      OP_MUL:  res = gsel * acc_q;
      OP_LEU:  res = {{(DATA_W-1){1'b0}}, (gsel <= acc_q)};
      OP_OR:   res = gsel | acc_q;
      OP_NAND: res = ~(gsel & acc_q);
      default: alu_op = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      for (int i = 0; i < NREG; i++) gr_q[i] <= '0;
    end else if (en) begin
      if (alu_op) begin
        if (dsel) gr_q[rsel] <= res;
        else      acc_q      <= res;
      end else begin
        unique case (op)
          OP_LOOP: acc_q <= acc_q - 1'b1;
          OP_SETK: acc_q <= konst;
          OP_ADDK: acc_q <= acc_q + konst;
          OP_INC1: acc_q <= acc_q + 1'b1;
          OP_XFER: begin
            if (dsel) gr_q[rsel] <= acc_q;
            else      acc_q      <= gsel;
          end
          default: ;
        endcase
      end
    end
  end

  AST_LOOP_DEC: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_LOOP) |=> acc_q == $past(acc_q) - 1'b1); // R5

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_IDLE0 || op == OP_IDLE1)) |=> $stable(acc_q)); // R10

endmodule

// File: rtl/bytecore.sv
module bytecore
  import bytecore_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pm_addr,
  input  logic [7:0]      pm_data,
  output logic [7:0]      out_data,
  output logic            out_valid,
  input  logic            out_ready
);

  instr_t            instr;
  op_e               op;
  logic [3:0]        narg;
  logic              fetched_q;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   entry;
  logic [PC_W-1:0]   pc_next;
  logic [PC_W-1:0]   ret_addr;
  logic [DATA_W-1:0] acc;
  logic              stall;
  logic              exec;
  logic              loop_taken;
  logic [7:0]        out_data_q;
  logic              out_valid_q;

  assign instr = instr_t'(pm_data);
  assign op    = instr.op;
  assign narg  = instr.arg;

  assign stall  = out_valid_q && !out_ready;
  assign exec   = fetched_q && !stall;
  assign pc_inc = pc_q + 1'b1;
  assign entry  = PC_W'({narg, 4'b0000});
  // new accumulator is nonzero unless the old one was 1
  assign loop_taken = (acc != DATA_W'(1));

  always_comb begin
    unique case (op)
      OP_JSR:  pc_next = entry;
      OP_RET:  pc_next = ret_addr;
      OP_LOOP: pc_next = loop_taken ? entry : pc_inc;
      default: pc_next = pc_inc;
    endcase
  end

  assign pm_addr = exec ? pc_next : pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetched_q <= 1'b0;
      pc_q      <= '0;
    end else begin
      fetched_q <= 1'b1;
      if (exec) pc_q <= pc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (exec && op == OP_EMIT) begin
        out_valid_q <= 1'b1;
        out_data_q  <= acc[7:0];
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  bytecore_rstack #(.PC_W(PC_W)) u_rstack (
    .clk       (clk),
    .rst       (rst),
    .push      (exec && op == OP_JSR),
    .pop       (exec && op == OP_RET),
    .push_addr (pc_inc),
    .ret_addr  (ret_addr)
  );

  bytecore_exec #(.DATA_W(DATA_W)) u_exec (
    .clk  (clk),
    .rst  (rst),
    .en   (exec),
    .op   (op),
    .dsel (narg[3]),
    .rsel (narg[RIDX_W-1:0]),
    .narg (narg),
    .acc  (acc)
  );

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (exec && !(op inside {OP_JSR, OP_RET, OP_LOOP})) |=> pc_q == $past(pc_q) + 1'b1); // R2

  AST_JSR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_JSR) |=> pc_q == PC_W'({$past(narg), 4'b0000})); // R3

  AST_EMIT_BYTE: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_EMIT) |=> out_valid && out_data == $past(acc[7:0])); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R6

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_q)); // R11

endmodule

// File: tb/tb_bytecore.sv
module tb_bytecore;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pm_addr;
  logic [7:0] pm_data;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;

  bytecore dut (
    .clk       (clk),
    .rst       (rst),
    .pm_addr   (pm_addr),
    .pm_data   (pm_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );

  always #2 clk = ~clk;

  logic [7:0] prog [256];
  always_ff @(posedge clk) pm_data <= prog[pm_addr];

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       armed = 1'b0;
  logic       bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  // back-pressure pattern, changed shortly after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_en ? (lfsr[0] & lfsr[2]) : 1'b1;
  end

  // monitor: compare accepted bytes, check holding while stalled
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = 8'h00;
  always @(negedge clk) begin
    if (!rst && armed) begin
      if (prev_stall) begin
        chk(out_valid == 1'b1 && out_data == prev_data, "R6", "held byte while stalled",
            {out_valid, out_data}, {1'b1, prev_data});
      end
      if (out_valid && out_ready && exp_q.size() != 0) begin
        chk(out_data == exp_q[0], tag_q[0], "emitted byte", out_data, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      prev_stall <= out_valid && !out_ready;
      prev_data  <= out_data;
    end else begin
      prev_stall <= 1'b0;
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'h0B;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    armed = 1'b0;
    rst   = 1'b1;
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic leave_reset();
    repeat (3) @(negedge clk);
    chk(pm_addr == 8'h00 && out_valid == 1'b0, "R1", "state in reset",
        {out_valid, pm_addr}, 0);
    armed = 1'b1;
    rst   = 1'b0;
  endtask

  task automatic wait_drain(input int limit, input string req);
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, "all expected bytes emitted", exp_q.size(), 0);
    armed = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // ---- calls, returns, loop branch, empty-stack return (R3 R4 R5)
    enter_reset();
    clear_prog();
    prog[8'h00] = 8'hB4; // A = 3
    prog[8'h01] = 8'h21; // call entry 2
    prog[8'h02] = 8'h03; // emit
    prog[8'h03] = 8'h31; // call entry 3
    prog[8'h04] = 8'h00; // unmatched return -> 0
    prog[8'h20] = 8'h03; // emit
    prog[8'h21] = 8'h00; // return
    prog[8'h30] = 8'h03; // emit
    prog[8'h31] = 8'h32; // loop to entry 3
    prog[8'h32] = 8'h00; // return
    for (int k = 0; k < 2; k++) begin
      push_exp(8'h03, "R3");
      push_exp(8'h03, "R3");
      push_exp(8'h03, "R5");
      push_exp(8'h02, "R5");
      push_exp(8'h01, "R5");
    end
    leave_reset();
    wait_drain(500, "R4");

    // ---- reset clears the stack: unmatched return lands at 0 (R1 R4)
    enter_reset();
    clear_prog();
    prog[8'h00] = 8'h94; // A = 1
    prog[8'h01] = 8'h03; // emit
    prog[8'h02] = 8'h00; // return with empty stack
    prog[8'h04] = 8'hF4; // A = 7, reached only with stale stack
    prog[8'h05] = 8'h03;
    push_exp(8'h01, "R1");
    push_exp(8'h01, "R4");
    push_exp(8'h01, "R4");
    leave_reset();
    wait_drain(200, "R1");

    // ---- PC wrap and back-pressure (R2 R6 R11)
    enter_reset();
    clear_prog();
    prog[8'h00] = 8'h94; // A = 1
    prog[8'h01] = 8'hF1; // call entry 15
    for (int i = 0; i < 16; i++) prog[8'hF0 + i] = (i % 2 == 0) ? 8'h03 : 8'h06;
    for (int k = 0; k < 2; k++)
      for (int v = 1; v <= 8; v++) push_exp(8'(v), (k == 0) ? "R6" : "R2");
    bp_en = 1'b1;
    leave_reset();
    wait_drain(3000, "R2");
    bp_en = 1'b0;

    // ---- data operations (R1 R7 R8 R9 R10 R11)
    enter_reset();
    clear_prog();
    prog[0]  = 8'h57; // A = G5
    prog[1]  = 8'h03;
    prog[2]  = 8'hD4; // A = 5
    prog[3]  = 8'h03;
    prog[4]  = 8'h25; // A += -6
    prog[5]  = 8'h03;
    prog[6]  = 8'h06; // A += 1
    prog[7]  = 8'h03;
    prog[8]  = 8'hB4; // A = 3
    prog[9]  = 8'hA7; // G2 = A
    prog[10] = 8'hF4; // A = 7
    prog[11] = 8'h28; // A = G2 + A
    prog[12] = 8'h03;
    prog[13] = 8'h29; // A = G2 - A
    prog[14] = 8'h03;
    prog[15] = 8'h2A; // A = G2 * A
    prog[16] = 8'h03;
    prog[17] = 8'h2D; // A = G2 <= A unsigned
    prog[18] = 8'h03;
    prog[19] = 8'hC4; // A = 4
    prog[20] = 8'hAE; // G2 = G2 | A
    prog[21] = 8'h84; // A = 0
    prog[22] = 8'h27; // A = G2
    prog[23] = 8'h03;
    prog[24] = 8'h2F; // A = ~(G2 & A)
    prog[25] = 8'h03;
    prog[26] = 8'h0B; // idle
    prog[27] = 8'hFC; // idle
    prog[28] = 8'h03;
    prog[29] = 8'hA4; // A = 2
    prog[30] = 8'h2D; // A = G2 <= A
    prog[31] = 8'h03;
    prog[32] = 8'hD4; // A = 5
    prog[33] = 8'hB8; // G3 = G3 + A
    prog[34] = 8'h84; // A = 0
    prog[35] = 8'h37; // A = G3
    prog[36] = 8'h03;
    prog[37] = 8'hF1; // park in entry 15
    prog[8'hF0] = 8'hF1;
    push_exp(8'h00, "R1");
    push_exp(8'h05, "R7");
    push_exp(8'hFF, "R7");
    push_exp(8'h00, "R7");
    push_exp(8'h0A, "R9");
    push_exp(8'hF9, "R9");
    push_exp(8'hEB, "R9");
    push_exp(8'h01, "R9");
    push_exp(8'h07, "R8");
    push_exp(8'hF8, "R9");
    push_exp(8'hF8, "R10");
    push_exp(8'h00, "R9");
    push_exp(8'h05, "R9");
    leave_reset();
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(pm_addr == 8'(k), "R11", "fetch address per cycle", pm_addr, k);
    end
    wait_drain(300, "R11");
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0 && pm_addr == 8'hF0, "R3", "parked in self call",
        {out_valid, pm_addr}, 8'hF0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule